// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Clear and Power-Down Response

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources, picked by a static configuration input. One source is a slow dedicated oscillator that reaches the block as a single-cycle tick. The other is the instruction clock, which ticks on every fourth system clock. The count passes through a fixed divide-by-256 stage and then through a prescaler whose ratio is 2^sel for a 3-bit select. When the selected prescaler stage overflows, the watchdog expires. It issues a one-cycle reset request and then starts counting again from zero.

Software keeps the watchdog from expiring by clearing it. A configuration input picks one of two clear modes. In single mode one clear strobe is enough. In dual mode two different half-commands must both arrive, in either order, and repeating the same half does nothing. A halt strobe also clears the counters. The response to an expiry depends on power state. With the core running, expiry requests a full device reset and sets a sticky time-out flag. With the core powered down, expiry requests only a reduced reset of the program counter and stack pointer. When the source is the instruction clock, power-down stops the count entirely. A disable input turns the whole block off.

Top module: `wdog_dualclr`

## Requirements
- R1: While `rst` is high, `dev_rst_req`, `pc_sp_rst_req` and `to_flag` are 0, both counter stages are zero, and any dual-mode half-command that was pending is discarded.
- R2: With `cfg_src_insn`=0, an expiry occurs after 256*2^`prescale_sel` oscillator ticks, counted from release of reset or from the last clear. `prescale_sel` is a binary value 0..7, so 7 gives the 1:128 ratio.
- R3: With `cfg_src_insn`=1, the count advances once every 4 system clocks, so an expiry occurs 1024*2^`prescale_sel` clocks after release of reset.
- R4: With `cfg_src_insn`=1 and `pwr_down`=1, the count does not advance and no expiry occurs.
- R5: Each expiry request lasts exactly one clock. Counting restarts from zero, so expiries repeat with the same period.
- R6: An expiry with `pwr_down`=0 pulses `dev_rst_req` and sets `to_flag`. `to_flag` stays set until `rst`.
- R7: An expiry with `pwr_down`=1 pulses `pc_sp_rst_req` only. `dev_rst_req` stays 0 and `to_flag` is unchanged.
- R8: With `cfg_enable`=0, no expiry occurs. Every clear strobe has no effect, including on the dual-mode pending state.
- R9: With `cfg_dual_clr`=0, a `clr_single` strobe clears both stages on the clock that samples it, and this wins over a tick in the same clock. `clr_half_a` and `clr_half_b` are ignored.
- R10: With `cfg_dual_clr`=1, a `clr_half_a` and a `clr_half_b` in either order clear the counters on the second one, even when other clocks lie between them. `clr_single` is ignored.
- R11: In dual mode, repeating the same half-command has no effect. After a completed pair, nothing is pending, so one further half-command does not clear.
- R12: `halt_strobe` clears both stages in either clear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| cfg_enable | input | 1 | 1 enables the watchdog |
| cfg_src_insn | input | 1 | Source select: 0 oscillator tick, 1 instruction clock (clk/4) |
| cfg_dual_clr | input | 1 | Clear mode: 0 single strobe, 1 two-step pair |
| osc_tick | input | 1 | One-cycle tick from the dedicated oscillator |
| pwr_down | input | 1 | Core is in power-down |
| prescale_sel | input | 3 | Prescaler select; ratio 2^value |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_half_a | input | 1 | First dual-mode half-command |
| clr_half_b | input | 1 | Second dual-mode half-command |
| halt_strobe | input | 1 | Halt entry, clears the counters |
| dev_rst_req | output | 1 | One-cycle full device reset request |
| pc_sp_rst_req | output | 1 | One-cycle program counter and stack pointer reset request |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The bench sweeps every prescaler select with the oscillator source, plus the three shortest selects with the instruction clock. The measured period therefore separates the fixed stage, the prescaler ratio and the divide-by-four. Clear patterns are placed at a known point in the count, so the remaining time until expiry shows whether a clear took effect. These patterns cover a single strobe, halves in both orders, repeated halves, a half that follows a completed pair, a half issued before reset or while disabled, and the halt strobe. Power-down runs tell apart the reduced reset from the full one, and a frozen count from a running one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_A    = 2'd1,
        PEND_B    = 2'd2
    } pend_e;

    typedef enum logic {
        SRC_OSC  = 1'b0,
        SRC_INSN = 1'b1
    } src_e;

    typedef struct packed {
        logic single;
        logic half_a;
        logic half_b;
        logic halt;
    } clr_req_t;

    // low-bit mask covering the prescaler stages that one select value spans
    function automatic int unsigned span_mask(input int unsigned sel);
        return (32'd1 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/wdog_src_tick.sv
module wdog_src_tick
    import wdog_pkg::*;
#(
    parameter int INSN_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  src_e src_sel,
    input  logic osc_tick,
    input  logic pwr_down,
    output logic tick
);
    localparam int DIV_W = (INSN_DIV > 1) ? $clog2(INSN_DIV) : 1;

    logic insn_tick;

    generate
        if (INSN_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (!pwr_down) begin
                    div_q <= (div_q == DIV_W'(INSN_DIV - 1)) ? '0 : div_q + 1'b1;
                end
            end

            assign insn_tick = !pwr_down && (div_q == DIV_W'(INSN_DIV - 1));

            // system clock stops in power-down, so the divider must hold
            assert_div_frozen_R4: assert property (@(posedge clk) disable iff (rst)
                pwr_down |=> $stable(div_q));
        end else begin : g_nodiv
            assign insn_tick = !pwr_down;
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        if (enable) begin
            tick = (src_sel == SRC_INSN) ? insn_tick : osc_tick;
        end
    end

endmodule

// File: rtl/wdog_clr_ctl.sv
module wdog_clr_ctl
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     dual_mode,
    input  clr_req_t req,
    output logic     clr
);
    pend_e pend_q, pend_d;
    logic  pair_done;
    logic  single_ok;

    always_comb begin
        pend_d    = pend_q;
        pair_done = 1'b0;
        if (enable && dual_mode) begin
            if (req.half_a && req.half_b) begin
                pair_done = 1'b1;
            end else if (req.half_a) begin
                if (pend_q == PEND_B) pair_done = 1'b1;
                else                  pend_d    = PEND_A;
            end else if (req.half_b) begin
                if (pend_q == PEND_A) pair_done = 1'b1;
                else                  pend_d    = PEND_B;
            end
            if (pair_done) pend_d = PEND_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= PEND_NONE;
        else     pend_q <= pend_d;
    end

    assign single_ok = enable && !dual_mode && req.single;
    assign clr       = single_ok || pair_done || (enable && req.halt);

    assert_repeat_noclr_R11: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && req.half_a && !req.half_b && !req.halt && pend_q == PEND_A) |-> !clr);

    assert_pair_idle_R11: assert property (@(posedge clk) disable iff (rst)
        pair_done |=> (pend_q == PEND_NONE));

    assert_off_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(pend_q));

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int FIX_STAGES = 8,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tmo_pulse
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [FIX_STAGES-1:0] pre_q;
    logic [PS_W-1:0]       ps_q;
    logic [PS_W-1:0]       mask;
    logic                  carry;
    logic                  wrap;

    assign mask  = PS_W'(span_mask(32'(sel)));
    assign carry = tick && (&pre_q);
    assign wrap  = carry && ((ps_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q     <= '0;
            ps_q      <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= wrap;
            if (tick) pre_q <= pre_q + 1'b1;
            if (wrap)       ps_q <= '0;
            else if (carry) ps_q <= ps_q + 1'b1;
        end
    end

    assert_clear_zero_R12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre_q == '0 && ps_q == '0 && !tmo_pulse));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> ($stable(pre_q) && $stable(ps_q) && !tmo_pulse));

    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |=> !tmo_pulse);

endmodule

// File: rtl/wdog_dualclr.sv
module wdog_dualclr
    import wdog_pkg::*;
#(
    parameter int FIX_STAGES = 8,
    parameter int SEL_W      = 3,
    parameter int INSN_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_src_insn,
    input  logic             cfg_dual_clr,
    input  logic             osc_tick,
    input  logic             pwr_down,
    input  logic [SEL_W-1:0] prescale_sel,
    input  logic             clr_single,
    input  logic             clr_half_a,
    input  logic             clr_half_b,
    input  logic             halt_strobe,
    output logic             dev_rst_req,
    output logic             pc_sp_rst_req,
    output logic             to_flag
);
    clr_req_t req;
    logic     tick;
    logic     clr_ok;
    logic     tmo;

    assign req = '{single: clr_single, half_a: clr_half_a,
                   half_b: clr_half_b, halt: halt_strobe};

    wdog_src_tick #(.INSN_DIV(INSN_DIV)) u_src (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_enable),
        .src_sel  (src_e'(cfg_src_insn)),
        .osc_tick (osc_tick),
        .pwr_down (pwr_down),
        .tick     (tick)
    );

    wdog_clr_ctl u_clr (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .dual_mode (cfg_dual_clr),
        .req       (req),
        .clr       (clr_ok)
    );

    wdog_count #(.FIX_STAGES(FIX_STAGES), .SEL_W(SEL_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .clr       (clr_ok || !cfg_enable),
        .sel       (prescale_sel),
        .tmo_pulse (tmo)
    );

    assign dev_rst_req   = tmo && !pwr_down;
    assign pc_sp_rst_req = tmo && pwr_down;

    always_ff @(posedge clk) begin
        if (rst)              to_flag <= 1'b0;
        else if (dev_rst_req) to_flag <= 1'b1;
    end

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        to_flag |=> to_flag);

    assert_pd_noflag_R7: assert property (@(posedge clk) disable iff (rst)
        pc_sp_rst_req |=> $stable(to_flag));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (!dev_rst_req && !pc_sp_rst_req));

endmodule

// File: tb/wdog_dualclr_bench.sv
module wdog_dualclr_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b1;
    logic       cfg_src_insn = 1'b0;
    logic       cfg_dual_clr = 1'b0;
    logic       osc_tick = 1'b1;
    logic       pwr_down = 1'b0;
    logic [2:0] prescale_sel = 3'd0;
    logic       clr_single = 1'b0;
    logic       clr_half_a = 1'b0;
    logic       clr_half_b = 1'b0;
    logic       halt_strobe = 1'b0;
    logic       dev_rst_req, pc_sp_rst_req, to_flag;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_dualclr u_wdog_dualclr (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src_insn(cfg_src_insn),
        .cfg_dual_clr(cfg_dual_clr), .osc_tick(osc_tick), .pwr_down(pwr_down),
        .prescale_sel(prescale_sel), .clr_single(clr_single), .clr_half_a(clr_half_a),
        .clr_half_b(clr_half_b), .halt_strobe(halt_strobe), .dev_rst_req(dev_rst_req),
        .pc_sp_rst_req(pc_sp_rst_req), .to_flag(to_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where rst was dropped
    task automatic restart(input logic en, input logic src, input logic dual,
                           input logic pd, input int sel);
        cfg_enable = en; cfg_src_insn = src; cfg_dual_clr = dual;
        pwr_down = pd; prescale_sel = 3'(sel); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 dev_rst_req in reset", int'(dev_rst_req), 0);
        check("R1 pc_sp_rst_req in reset", int'(pc_sp_rst_req), 0);
        check("R1 to_flag in reset", int'(to_flag), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // 0 single, 1 half a, 2 half b, 3 halt; held for one sampling edge
    task automatic strobe(input int which);
        case (which)
            0: clr_single = 1'b1;
            1: clr_half_a = 1'b1;
            2: clr_half_b = 1'b1;
            default: halt_strobe = 1'b1;
        endcase
        @(negedge clk);
        clr_single = 1'b0; clr_half_a = 1'b0; clr_half_b = 1'b0; halt_strobe = 1'b0;
    endtask

    // cycles until a reset request is seen, 0 if none within lim
    task automatic measure(input int lim, output int n, output int dev, output int pcs);
        n = 0; dev = 0; pcs = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (dev_rst_req || pc_sp_rst_req) begin
                n = i; dev = int'(dev_rst_req); pcs = int'(pc_sp_rst_req);
                break;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, dev, pcs;
        @(negedge clk);

        // R2: oscillator source, every select
        for (int w = 0; w < 8; w++) begin
            restart(1'b1, 1'b0, 1'b0, 1'b0, w);
            measure(40000, n, dev, pcs);
            check($sformatf("R2 period sel=%0d", w), n, 256 << w);
        end

        // R3: instruction clock source
        for (int w = 0; w < 3; w++) begin
            restart(1'b1, 1'b1, 1'b0, 1'b0, w);
            measure(40000, n, dev, pcs);
            check($sformatf("R3 period sel=%0d", w), n, 1024 << w);
        end

        // R4: instruction clock frozen in power-down
        restart(1'b1, 1'b1, 1'b0, 1'b1, 0);
        measure(6000, n, dev, pcs);
        check("R4 no expiry in power-down", n, 0);

        // R5 / R6: repeat period, one-cycle pulse, sticky flag
        restart(1'b1, 1'b0, 1'b0, 1'b0, 0);
        measure(1000, n, dev, pcs);
        check("R6 first expiry is device reset", dev, 1);
        check("R6 no reduced reset when running", pcs, 0);
        measure(1000, n, dev, pcs);
        check("R5 restart period", n, 256);
        @(negedge clk);
        check("R6 to_flag set", int'(to_flag), 1);
        repeat (300) @(negedge clk);
        check("R6 to_flag sticky", int'(to_flag), 1);

        // R7: oscillator source in power-down
        restart(1'b1, 1'b0, 1'b0, 1'b1, 0);
        measure(1000, n, dev, pcs);
        check("R7 period in power-down", n, 256);
        check("R7 reduced reset", pcs, 1);
        check("R7 no device reset", dev, 0);
        @(negedge clk);
        check("R7 to_flag unchanged", int'(to_flag), 0);

        // R8: disabled
        restart(1'b0, 1'b0, 1'b0, 1'b0, 0);
        measure(2000, n, dev, pcs);
        check("R8 no expiry when disabled", n, 0);
        restart(1'b0, 1'b0, 1'b1, 1'b0, 1);
        strobe(1);
        repeat (10) @(negedge clk);
        cfg_enable = 1'b1;
        repeat (100) @(negedge clk);
        strobe(2);
        measure(1000, n, dev, pcs);
        check("R8 half while disabled not kept", n, 411);

        // R9: single mode
        restart(1'b1, 1'b0, 1'b0, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(0);
        measure(1000, n, dev, pcs);
        check("R9 single strobe clears", n, 512);
        restart(1'b1, 1'b0, 1'b0, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1); strobe(2);
        measure(1000, n, dev, pcs);
        check("R9 halves ignored in single mode", n, 410);

        // R10: dual mode pairs
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(2); strobe(1);
        measure(1000, n, dev, pcs);
        check("R10 pair b then a", n, 512);
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1);
        repeat (50) @(negedge clk); strobe(2);
        measure(1000, n, dev, pcs);
        check("R10 pair a then b with gap", n, 512);
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(0);
        measure(1000, n, dev, pcs);
        check("R10 single ignored in dual mode", n, 411);

        // R11: repeats and state after a pair
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1); strobe(1);
        measure(1000, n, dev, pcs);
        check("R11 repeated half a", n, 410);
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1); strobe(1); strobe(2);
        measure(1000, n, dev, pcs);
        check("R11 half b completes after repeats", n, 512);
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1); strobe(2); strobe(2);
        measure(1000, n, dev, pcs);
        check("R11 nothing pending after pair", n, 511);

        // R1: pending half discarded by reset
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(1);
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(2);
        measure(1000, n, dev, pcs);
        check("R1 pending cleared by reset", n, 411);

        // R12: halt in both modes
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(3);
        measure(1000, n, dev, pcs);
        check("R12 halt clears dual mode", n, 512);
        restart(1'b1, 1'b0, 1'b0, 1'b0, 1);
        repeat (100) @(negedge clk); strobe(3);
        measure(1000, n, dev, pcs);
        check("R12 halt clears single mode", n, 512);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule